// File: doc/BRIEF.md
# Single-Channel Memory-Mapped DMA Engine

This block is one DMA channel that software drives through four 32-bit registers: a source pointer, a destination pointer, a live count of remaining transfer cycles, and a control word. Once software sets the enable bit, the channel repeats transfer cycles until the count reaches zero. Each cycle holds one beat, or four beats in burst mode. In each beat the channel reads one element from the source pointer over a simple request/acknowledge master port and writes it to the destination pointer. After every beat each pointer moves by a signed step. The step comes from a 3-bit code in the control word and is four times larger in burst mode.

A transfer can run freely, or it can wait for numbered peripheral request lines before each cycle. In the waiting case it returns a one-clock grant pulse on the same line number when the cycle's last beat is written. Completion and bus errors each set a sticky status flag. Software clears a flag by writing the control word with that bit at 0. Each flag has its own enable that gates it onto the interrupt output.

The sequencer has four states. `ST_IDLE` goes to `ST_WAIT` when enable is set. `ST_WAIT` goes to `ST_READ` once the selected request lines are high (or immediately when no line is selected), and returns to `ST_IDLE` if software has dropped enable. `ST_READ` goes to `ST_WRITE` on an error-free acknowledge and to `ST_IDLE` on an error acknowledge. `ST_WRITE` goes to `ST_READ` for the next beat of a cycle. At the end of a cycle it goes back to `ST_WAIT`, or to `ST_IDLE` when the last cycle completes, when enable is low, or on an error acknowledge.

Top module: `dmac_channel`

## Requirements
- R1: After reset all four registers read 0, `irq` is 0 and `m_req` is 0.
- R2: `reg_sel` 0, 1, 2 and 3 select source pointer, destination pointer, count (24 bits, upper bits read 0) and control. In the control word, bits 31:28, 22, 23, 15 and 11 always read 0.
- R3: Control fields: bit 0 enable, 1 finish status, 2 finish interrupt enable, 3 burst, 4 error status, 5 error interrupt enable, 6/7 source/destination bus select, 10:8 source step code, 14:12 destination step code, 19:16 destination request line, 21:20 element width, 27:24 source request line. Step codes 0..7 give 0, +1, +2, +4, 0, -1, -2, -4 bytes, and burst mode multiplies the step by 4.
- R4: Each beat reads the source pointer and then writes the word it read to the destination pointer. A cycle is 1 beat without burst and 4 beats with burst. The pointer registers hold the stepped values afterwards.
- R5: The count drops by one at the end of each completed cycle, and a read returns the remaining cycles.
- R6: When the last cycle completes, finish status is set and enable clears on the same clock edge.
- R7: Writing enable=1 while the count is 0 sets finish status and leaves enable at 0, with no bus access.
- R8: Writing a 0 to a status bit clears it. Writing a 1 never sets it.
- R9: `irq` = (finish status AND finish enable) OR (error status AND error enable).
- R10: An acknowledge with `m_err` set sets error status and clears enable. No further access follows, and the count keeps the number of cycles not yet completed.
- R11: With a nonzero request line selected, no cycle starts until `dma_req` of that line is high. After each cycle's last write, `dma_ack` of each selected line pulses for exactly one clock.
- R12: Writes to the pointer and count registers are ignored while enable is set.
- R13: `m_addr` and `m_we` hold stable until acknowledged. `m_size` carries the width field, and `m_sel` carries the source bus select on reads and the destination bus select on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` (combinational) |
| m_req | output | 1 | Master access request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_size | output | 2 | Element width: 0 word, 1 halfword, 2 byte |
| m_sel | output | 1 | Bus select for this access (1 = system bus) |
| m_ack | input | 1 | Access complete |
| m_err | input | 1 | Error response, valid with `m_ack` |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| dma_req | input | 16 | Peripheral request lines (line 0 unused) |
| dma_ack | output | 16 | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every source and destination step code with and without burst, including the reserved code 4. It varies acknowledge latency, width and bus select, and traces every bus access against addresses computed arithmetically. A stepper with a wrong sign or a missing burst multiplier would put beats at wrong addresses or leave wrong final pointers. A beat counter that is off by one would show up as a wrong access count per cycle. Separate tests cover the following corner cases: a zero-count enable, which a naive design would treat as a 2^24-cycle run; an error in mid-cycle, where a faulty design would keep issuing accesses or decrement the count; a stalled handshake, where a design that ignores the request line, or pulses the grant twice, would change the access and pulse counts; and writes to running registers or set-by-one status bits, which a faulty design would let take effect.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int LINE_W   = 4;

    localparam int CB_EN    = 0;
    localparam int CB_FIN   = 1;
    localparam int CB_FIE   = 2;
    localparam int CB_BURST = 3;
    localparam int CB_ERR   = 4;
    localparam int CB_EIE   = 5;
    localparam int CB_SSYS  = 6;
    localparam int CB_DSYS  = 7;
    localparam int CB_SCODE = 8;
    localparam int CB_DCODE = 12;
    localparam int CB_DLINE = 16;
    localparam int CB_WIDTH = 20;
    localparam int CB_SLINE = 24;

    // plain configuration bits kept in storage (status and enable live apart)
    localparam logic [31:0] CFG_MASK = 32'h0F3F_77EC;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE
    } seq_state_t;

    // signed byte step for a 3-bit code; reserved code 4 gives no movement
    function automatic logic signed [5:0] step_amount(input logic [2:0] code,
                                                      input logic burst);
        logic [5:0] mag;
        case (code[1:0])
            2'd0:    mag = 6'd0;
            2'd1:    mag = 6'd1;
            2'd2:    mag = 6'd2;
            default: mag = 6'd4;
        endcase
        if (burst) mag = mag << 2;
        return code[2] ? -$signed(mag) : $signed(mag);
    endfunction
endpackage

// File: rtl/dmac_stepper.sv
module dmac_stepper
    import dmac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [2:0]    code,
    input  logic          burst,
    output logic [AW-1:0] next
);
    logic signed [5:0] step;
    logic [AW-1:0]     delta;

    always_comb begin
        step  = step_amount(code, burst);
        delta = {{(AW-6){step[5]}}, step};
        next  = addr + delta;
    end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              src_adv,
    input  logic              dst_adv,
    input  logic              cyc_done,
    input  logic              hit_err,
    output logic              chan_en,
    output logic              burst,
    output logic              src_sys,
    output logic              dst_sys,
    output logic [1:0]        width,
    output logic [LINE_W-1:0] src_line,
    output logic [LINE_W-1:0] dst_line,
    output logic [AW-1:0]     src_addr,
    output logic [AW-1:0]     dst_addr,
    output logic              cnt_is_one,
    output logic              fin_flag,
    output logic              err_flag,
    output logic              fin_ie,
    output logic              err_ie
);
    localparam int NPTR = 2;

    logic [AW-1:0] ptr_q  [NPTR];
    logic [AW-1:0] ptr_nx [NPTR];
    logic [2:0]    code   [NPTR];
    logic [NPTR-1:0] adv;
    logic [NPTR-1:0] wr_ptr;
    logic [CW-1:0] cnt_q;
    logic [31:0]   cfg_q;
    logic          en_q, fin_q, err_q;
    logic          ctrl_wr, cnt_wr, finish_now, zero_start;

    assign code[0]   = cfg_q[CB_SCODE +: 3];
    assign code[1]   = cfg_q[CB_DCODE +: 3];
    assign adv       = {dst_adv, src_adv};
    assign wr_ptr[0] = reg_we && (reg_sel == 2'd0);
    assign wr_ptr[1] = reg_we && (reg_sel == 2'd1);
    assign cnt_wr    = reg_we && (reg_sel == 2'd2);
    assign ctrl_wr   = reg_we && (reg_sel == 2'd3);
    assign finish_now = cyc_done && (cnt_q == CW'(1));
    assign zero_start = ctrl_wr && reg_wdata[CB_EN] && (cnt_q == '0);

    generate
        for (genvar p = 0; p < NPTR; p++) begin : g_ptr
            dmac_stepper #(.AW(AW)) u_step (
                .addr  (ptr_q[p]),
                .code  (code[p]),
                .burst (cfg_q[CB_BURST]),
                .next  (ptr_nx[p])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPTR; p++) ptr_q[p] <= '0;
            cnt_q <= '0;
            cfg_q <= '0;
            en_q  <= 1'b0;
            fin_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            for (int p = 0; p < NPTR; p++) begin
                if (wr_ptr[p] && !en_q)  ptr_q[p] <= reg_wdata[AW-1:0];
                else if (adv[p])         ptr_q[p] <= ptr_nx[p];
            end
            if (cnt_wr && !en_q)  cnt_q <= reg_wdata[CW-1:0];
            else if (cyc_done)    cnt_q <= cnt_q - CW'(1);

            if (ctrl_wr) cfg_q <= reg_wdata & CFG_MASK;

            if (finish_now || hit_err) en_q <= 1'b0;
            else if (ctrl_wr)          en_q <= reg_wdata[CB_EN] && (cnt_q != '0);

            if (finish_now || zero_start) fin_q <= 1'b1;
            else if (ctrl_wr)             fin_q <= fin_q & reg_wdata[CB_FIN];

            if (hit_err)      err_q <= 1'b1;
            else if (ctrl_wr) err_q <= err_q & reg_wdata[CB_ERR];
        end
    end

    always_comb begin
        unique case (reg_sel)
            2'd0:    reg_rdata = 32'(ptr_q[0]);
            2'd1:    reg_rdata = 32'(ptr_q[1]);
            2'd2:    reg_rdata = 32'(cnt_q);
            default: reg_rdata = cfg_q | {27'd0, err_q, 2'b00, fin_q, en_q};
        endcase
    end

    assign chan_en    = en_q;
    assign burst      = cfg_q[CB_BURST];
    assign src_sys    = cfg_q[CB_SSYS];
    assign dst_sys    = cfg_q[CB_DSYS];
    assign width      = cfg_q[CB_WIDTH +: 2];
    assign src_line   = cfg_q[CB_SLINE +: LINE_W];
    assign dst_line   = cfg_q[CB_DLINE +: LINE_W];
    assign src_addr   = ptr_q[0];
    assign dst_addr   = ptr_q[1];
    assign cnt_is_one = (cnt_q == CW'(1));
    assign fin_flag   = fin_q;
    assign err_flag   = err_q;
    assign fin_ie     = cfg_q[CB_FIE];
    assign err_ie     = cfg_q[CB_EIE];

    // R5 / R12: while running, a count write cannot load; only a decrement may occur
    a_r12_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CW'(1)));

    // R6: finish status rises only together with enable dropping
    a_r6_finish_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fin_q) |-> !en_q);

    // R7: enabling with an empty count finishes at once
    a_r7_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
        zero_start |=> (fin_q && !en_q));

    // R10: error status rises only together with enable dropping
    a_r10_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> !en_q);
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BEATS = 4,
    parameter int NL    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              burst,
    input  logic              src_sys,
    input  logic              dst_sys,
    input  logic [1:0]        width,
    input  logic [LINE_W-1:0] src_line,
    input  logic [LINE_W-1:0] dst_line,
    input  logic [AW-1:0]     src_addr,
    input  logic [AW-1:0]     dst_addr,
    input  logic              cnt_is_one,
    input  logic [NL-1:0]     dreq,
    input  logic              m_ack,
    input  logic              m_err,
    input  logic [31:0]       m_rdata,
    output logic              m_req,
    output logic              m_we,
    output logic [AW-1:0]     m_addr,
    output logic [31:0]       m_wdata,
    output logic [1:0]        m_size,
    output logic              m_sel,
    output logic              src_adv,
    output logic              dst_adv,
    output logic              cyc_done,
    output logic              hit_err,
    output logic [NL-1:0]     dack
);
    localparam int BEAT_W = $clog2(BEATS);

    seq_state_t        st_q, st_d;
    logic [BEAT_W-1:0] beat_q;
    logic [31:0]       data_q;
    logic [NL-1:0]     dack_q;
    logic [NL-1:0]     line_mask;
    logic              last_beat, src_ok, dst_ok, go;

    assign last_beat = !burst || (beat_q == BEAT_W'(BEATS - 1));
    assign src_ok    = (src_line == '0) || dreq[src_line];
    assign dst_ok    = (dst_line == '0) || dreq[dst_line];
    assign go        = src_ok && dst_ok;
    assign line_mask = ((src_line != '0) ? (NL'(1) << src_line) : '0)
                     | ((dst_line != '0) ? (NL'(1) << dst_line) : '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (chan_en) st_d = ST_WAIT;
            ST_WAIT:  begin
                if (!chan_en) st_d = ST_IDLE;
                else if (go)  st_d = ST_READ;
            end
            ST_READ:  if (m_ack) st_d = m_err ? ST_IDLE : ST_WRITE;
            ST_WRITE: begin
                if (m_ack) begin
                    if (m_err)                       st_d = ST_IDLE;
                    else if (!last_beat)             st_d = ST_READ;
                    else if (cnt_is_one || !chan_en) st_d = ST_IDLE;
                    else                             st_d = ST_WAIT;
                end
            end
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        m_req    = 1'b0;
        m_we     = 1'b0;
        m_addr   = '0;
        m_sel    = 1'b0;
        src_adv  = 1'b0;
        dst_adv  = 1'b0;
        hit_err  = 1'b0;
        unique case (st_q)
            ST_READ: begin
                m_req   = 1'b1;
                m_addr  = src_addr;
                m_sel   = src_sys;
                src_adv = m_ack && !m_err;
                hit_err = m_ack && m_err;
            end
            ST_WRITE: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = dst_addr;
                m_sel   = dst_sys;
                dst_adv = m_ack && !m_err;
                hit_err = m_ack && m_err;
            end
            default: ;
        endcase
        cyc_done = dst_adv && last_beat;
        m_wdata  = data_q;
        m_size   = width;
        dack     = dack_q;
    end

    // beat counter, data holding and grant pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            data_q <= '0;
            dack_q <= '0;
        end else begin
            if (st_q == ST_WAIT && go)       beat_q <= '0;
            else if (dst_adv && !last_beat)  beat_q <= beat_q + BEAT_W'(1);
            if (src_adv)                     data_q <= m_rdata;
            dack_q <= cyc_done ? line_mask : '0;
        end
    end

    // R13: an outstanding access keeps its address and direction
    a_r13_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    // R11: a grant follows only a successful write acknowledge
    a_r11_grant_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_q) |-> $past(st_q == ST_WRITE && m_ack && !m_err));

    // R10: an error response ends bus activity
    a_r10_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        hit_err |=> !m_req);
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 24,
    parameter int BEATS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [1:0]     reg_sel,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           m_req,
    output logic           m_we,
    output logic [AW-1:0]  m_addr,
    output logic [31:0]    m_wdata,
    output logic [1:0]     m_size,
    output logic           m_sel,
    input  logic           m_ack,
    input  logic           m_err,
    input  logic [31:0]    m_rdata,
    input  logic [15:0]    dma_req,
    output logic [15:0]    dma_ack,
    output logic           irq
);
    localparam int NL = 1 << LINE_W;

    logic              chan_en, burst, src_sys, dst_sys, cnt_is_one;
    logic [1:0]        width;
    logic [LINE_W-1:0] src_line, dst_line;
    logic [AW-1:0]     src_addr, dst_addr;
    logic              src_adv, dst_adv, cyc_done, hit_err;
    logic              fin_flag, err_flag, fin_ie, err_ie;

    dmac_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .reg_rdata,
        .src_adv, .dst_adv, .cyc_done, .hit_err,
        .chan_en, .burst, .src_sys, .dst_sys, .width,
        .src_line, .dst_line, .src_addr, .dst_addr, .cnt_is_one,
        .fin_flag, .err_flag, .fin_ie, .err_ie
    );

    dmac_seq #(.AW(AW), .BEATS(BEATS), .NL(NL)) u_seq (
        .clk, .rst_n, .chan_en, .burst, .src_sys, .dst_sys, .width,
        .src_line, .dst_line, .src_addr, .dst_addr, .cnt_is_one,
        .dreq (dma_req), .m_ack, .m_err, .m_rdata,
        .m_req, .m_we, .m_addr, .m_wdata, .m_size, .m_sel,
        .src_adv, .dst_adv, .cyc_done, .hit_err, .dack (dma_ack)
    );

    assign irq = (fin_flag & fin_ie) | (err_flag & err_ie);

    // R9: no interrupt without a pending status flag
    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!fin_flag && !err_flag) |-> !irq);
endmodule

// File: tb/dmac_channel_tb.sv
module dmac_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        m_req, m_we, m_sel;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;
    logic        m_ack, m_err;
    logic [15:0] dma_req = 16'd0;
    logic [15:0] dma_ack;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int acc_idx = 0, err_at = -1, lat = 0, wcnt = 0;
    int exp_s0, exp_d0, exp_ss, exp_sd, exp_base, exp_width, exp_ssys, exp_dsys;
    int dack_pulses = 0;
    logic [15:0] exp_dmask = 16'd0;
    logic dack_prev;
    bit done = 0;

    always #5 clk = ~clk;

    dmac_channel u_dut (
        .clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .reg_rdata,
        .m_req, .m_we, .m_addr, .m_wdata, .m_size, .m_sel,
        .m_ack, .m_err, .m_rdata, .dma_req, .dma_ack, .irq
    );

    function automatic logic [31:0] pattern(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic int step_of(input int code, input int burst);
        int mag;
        case (code % 4)
            0: mag = 0;
            1: mag = 1;
            2: mag = 2;
            default: mag = 4;
        endcase
        if (burst != 0) mag = mag * 4;
        return (code >= 4) ? -mag : mag;
    endfunction

    assign m_rdata = m_ack ? pattern(m_addr) : 32'd0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // slave model and bus trace checker
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ack <= 1'b0; m_err <= 1'b0; wcnt <= 0; dack_prev <= 1'b0;
        end else begin
            m_ack <= 1'b0; m_err <= 1'b0;
            if (m_req && m_ack) begin
                int k, b;
                logic [31:0] sa, da;
                k = acc_idx - exp_base;
                b = k / 2;
                sa = 32'(exp_s0 + b * exp_ss);
                da = 32'(exp_d0 + b * exp_sd);
                chk("R13 size", {30'd0, m_size}, 32'(exp_width));
                if (k % 2 == 0) begin
                    chk("R4 read dir", {31'd0, m_we}, 32'd0);
                    chk("R4 read addr", m_addr, sa);
                    chk("R13 read sel", {31'd0, m_sel}, 32'(exp_ssys));
                end else begin
                    chk("R4 write dir", {31'd0, m_we}, 32'd1);
                    chk("R4 write addr", m_addr, da);
                    chk("R4 write data", m_wdata, pattern(sa));
                    chk("R13 write sel", {31'd0, m_sel}, 32'(exp_dsys));
                end
                acc_idx <= acc_idx + 1;
            end else if (m_req) begin
                if (wcnt >= lat) begin
                    m_ack <= 1'b1; m_err <= (acc_idx == err_at); wcnt <= 0;
                end else wcnt <= wcnt + 1;
            end
            if (|dma_ack) begin
                dack_pulses <= dack_pulses + 1;
                chk("R11 grant lines", {16'd0, dma_ack}, {16'd0, exp_dmask});
                if (dack_prev) chk("R11 grant one clock", 32'd1, 32'd0);
            end
            dack_prev <= |dma_ack;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int en, fie, burst, eie, ssys, dsys,
                                              sc, dc, dline, width, sline);
        return 32'(en | (fie << 2) | (burst << 3) | (eie << 5) | (ssys << 6) | (dsys << 7)
                   | (sc << 8) | (dc << 12) | (dline << 16) | (width << 20) | (sline << 24));
    endfunction

    task automatic start_xfer(input int s0, d0, sc, dc, burst, cnt, width, ssys, dsys,
                              sline, dline, fie, eie, lat_i);
        exp_s0 = s0; exp_d0 = d0;
        exp_ss = step_of(sc, burst); exp_sd = step_of(dc, burst);
        exp_width = width; exp_ssys = ssys; exp_dsys = dsys;
        exp_base = acc_idx; lat = lat_i;
        exp_dmask = ((sline != 0) ? (16'd1 << sline) : 16'd0) | ((dline != 0) ? (16'd1 << dline) : 16'd0);
        wr(2'd0, 32'(s0));
        wr(2'd1, 32'(d0));
        wr(2'd2, 32'(cnt));
        wr(2'd3, ctrl_word(1, fie, burst, eie, ssys, dsys, sc, dc, dline, width, sline));
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(2'd3, c);
            if (c[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 4; s++) begin
            rd(2'(s), v);
            chk("R1 register zero", v, 32'd0);
        end
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 m_req", {31'd0, m_req}, 32'd0);

        // R2 map and readback
        wr(2'd0, 32'h1234_5678); rd(2'd0, v); chk("R2 source", v, 32'h1234_5678);
        wr(2'd1, 32'hCAFE_0010); rd(2'd1, v); chk("R2 destination", v, 32'hCAFE_0010);
        wr(2'd2, 32'hFFAB_CDEF); rd(2'd2, v); chk("R2 count 24 bits", v, 32'h00AB_CDEF);
        wr(2'd3, 32'hFFFF_FFFE); rd(2'd3, v); chk("R2 R8 control mask", v, 32'h0F3F_77EC);
        wr(2'd3, 32'd0);

        // R7 zero-count enable
        wr(2'd2, 32'd0);
        begin
            int base;
            base = acc_idx;
            wr(2'd3, ctrl_word(1, 1, 0, 0, 0, 0, 1, 1, 0, 0, 0));
            rd(2'd3, v);
            chk("R7 enable stays low", {31'd0, v[0]}, 32'd0);
            chk("R7 finish set", {31'd0, v[1]}, 32'd1);
            repeat (5) @(negedge clk);
            chk("R7 no access", 32'(acc_idx - base), 32'd0);
            chk("R9 finish irq", {31'd0, irq}, 32'd1);
        end

        // R8 status writes
        wr(2'd3, 32'h0000_0006); rd(2'd3, v);
        chk("R8 write one keeps status", {31'd0, v[1]}, 32'd1);
        wr(2'd3, 32'h0000_0004); rd(2'd3, v);
        chk("R8 write zero clears", {31'd0, v[1]}, 32'd0);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'h0000_0016); rd(2'd3, v);
        chk("R8 write one does not set", {27'd0, v[4], 2'b00, v[1], 1'b0}, 32'd0);

        // R3 R4 R5 R6 R9 step-code sweep
        for (int burst = 0; burst < 2; burst++) begin
            for (int sc = 0; sc < 8; sc++) begin
                for (int dc = 0; dc < 8; dc++) begin
                    int combo, cnt, beats, base, fie;
                    combo = burst * 64 + sc * 8 + dc;
                    cnt = 2 + (combo % 2);
                    beats = (burst != 0) ? 4 : 1;
                    fie = combo % 2;
                    base = acc_idx;
                    start_xfer(32'h8000, 32'h4_0000, sc, dc, burst, cnt, combo % 3,
                               sc % 2, (dc / 2) % 2, 0, 0, fie, 0, combo % 3);
                    wait_idle();
                    @(negedge clk);
                    rd(2'd3, v);
                    chk("R6 finish", {30'd0, v[1], v[0]}, 32'd2);
                    rd(2'd2, v);
                    chk("R5 count empty", v, 32'd0);
                    rd(2'd0, v);
                    chk("R3 source final", v, 32'(32'h8000 + beats * cnt * exp_ss));
                    rd(2'd1, v);
                    chk("R3 destination final", v, 32'(32'h4_0000 + beats * cnt * exp_sd));
                    chk("R4 access count", 32'(acc_idx - base), 32'(2 * beats * cnt));
                    chk("R9 irq follows enable", {31'd0, irq}, 32'(fie));
                    wr(2'd3, 32'd0);
                end
            end
        end

        // R11 R5 R12 handshake on source line 3
        begin
            int base, p0, s0v;
            base = acc_idx;
            p0 = dack_pulses;
            s0v = 32'h2000;
            start_xfer(s0v, 32'h3000, 1, 2, 0, 2, 0, 0, 1, 3, 0, 0, 0, 1);
            repeat (20) @(negedge clk);
            chk("R11 waits for request", 32'(acc_idx - base), 32'd0);
            dma_req[5] = 1'b1;
            repeat (10) @(negedge clk);
            chk("R11 other line ignored", 32'(acc_idx - base), 32'd0);
            dma_req[5] = 1'b0;
            dma_req[3] = 1'b1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (dma_ack[3]) break;
            end
            dma_req[3] = 1'b0;
            rd(2'd2, v);
            chk("R5 live count", v, 32'd1);
            repeat (10) @(negedge clk);
            chk("R11 stalls between cycles", 32'(acc_idx - base), 32'd2);
            wr(2'd0, 32'hDEAD_BEEF); rd(2'd0, v);
            chk("R12 source write ignored", v, 32'(s0v + 1));
            wr(2'd2, 32'd7); rd(2'd2, v);
            chk("R12 count write ignored", v, 32'd1);
            dma_req[3] = 1'b1;
            wait_idle();
            dma_req[3] = 1'b0;
            repeat (3) @(negedge clk);
            rd(2'd3, v);
            chk("R11 finish after handshake", {30'd0, v[1], v[0]}, 32'd2);
            chk("R11 grant pulses", 32'(dack_pulses - p0), 32'd2);
            wr(2'd3, 32'd0);
        end

        // R10 bus error on the second write
        begin
            int base;
            base = acc_idx;
            err_at = acc_idx + 3;
            start_xfer(32'h100, 32'h200, 1, 1, 0, 3, 0, 0, 0, 0, 0, 0, 1, 0);
            wait_idle();
            repeat (10) @(negedge clk);
            rd(2'd3, v);
            chk("R10 status", {27'd0, v[4], 2'b00, v[1], v[0]}, 32'h10);
            rd(2'd2, v);  chk("R10 count kept", v, 32'd2);
            rd(2'd0, v);  chk("R10 source pointer", v, 32'h102);
            rd(2'd1, v);  chk("R10 destination pointer", v, 32'h201);
            chk("R10 no more access", 32'(acc_idx - base), 32'd4);
            chk("R9 error irq", {31'd0, irq}, 32'd1);
            err_at = -1;
            wr(2'd3, 32'h0000_0020);
            rd(2'd3, v);
            chk("R8 error cleared", {31'd0, v[4]}, 32'd0);
            chk("R9 error irq cleared", {31'd0, irq}, 32'd0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule